// File: doc/BRIEF.md
# Pushbutton Power-State Sequencer

This block is the control state machine of a handheld power system. It watches an active-low pushbutton, a power-hold level driven by the host processor, and an undervoltage flag from a supply comparator. From these it decides when three switching regulators are enabled. It also drives a wake output, a power-good output and a pushbutton status output for the host. All durations are counted in ticks of an external one-cycle millisecond strobe, and each duration is a parameter.

There are four states: off, power-up, on and power-down wait. In the off state, a fresh button press starts power-up. During power-up the regulators come on one after another, and the machine reaches the on state once a settle time has passed. In the on state the host can power the system down by releasing its hold input. An undervoltage event sends the machine straight into the wait state. The wait state enforces a minimum off time during which every input is ignored. If undervoltage caused the shutdown, the machine powers back up by itself once the supply has recovered.

When the machine enters the wait state, it emits a one-cycle clear pulse. Downstream logic uses this pulse to reset the registers that enable the auxiliary linear regulators and the backlight. The sequencer never sets those registers again. All pins are plain control or status levels, so there is no streamed data and no back-pressure.

Top module: `pbs_power_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the machine is off with `wake`, `pgood`, `pb_stat`, `ctl_clr` and all of `buck_en` low. Without a press it stays off.
- R2: In the off state with `uv_flag` low, a press starts power-up, and `wake` and `buck_en[0]` rise within 4 clock cycles. A press means the synchronized `btn_n` reads 0 after it has read 1 at some point while the machine was off.
- R3: During power-up, `buck_en[i]` rises i×STEP_MS ticks after `buck_en[0]`, giving the order 0, 1, 2. When each bit rises, all lower bits are already high. `pgood` rises SETTLE_MS ticks after the last enable.
- R4: In the on state, `pb_stat` goes high once the button has been held low for PRESS_MS ticks. A shorter press leaves it low, and it drops within 4 cycles of release.
- R5: In the on state, `host_hold` held low for HOLD_MS consecutive ticks starts power-down. If it returns high earlier, the count restarts.
- R6: On entry to the wait state, `wake`, `pgood` and every `buck_en` bit fall in the same cycle. `ctl_clr` is high for that cycle only.
- R7: The wait state lasts OFF_MS ticks. Presses, releases, `host_hold` changes and `uv_flag` changes during the wait have no effect on any output.
- R8: A button held low from the wait into the off state does not start power-up. It must read high in the off state and then go low again.
- R9: `uv_flag` high in the power-up or on state moves the machine to the wait state on the next clock edge.
- R10: After an undervoltage shutdown, the machine spends one cycle off and then starts power-up without a press, provided `uv_flag` is low when the wait ends. If `uv_flag` is still high then, the machine stays off until it falls and then powers up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| host_hold | input | 1 | Host power-hold level, high keeps the system on |
| uv_flag | input | 1 | Undervoltage flag, high while the supply is low |
| pb_stat | output | 1 | High while a long press is seen in the on state |
| wake | output | 1 | High during power-up and on |
| pgood | output | 1 | High in the on state |
| buck_en | output | N_BUCK | Regulator enables, bit 0 first |
| ctl_clr | output | 1 | One-cycle pulse that clears regulator-control bits |

## Verification
Assertions check on every cycle that enables never rise out of order, that the enables, the clear pulse and `wake` fall together, and that `ctl_clr` lasts exactly one cycle. They also check that undervoltage drops `wake` on the next edge, and that the wait state holds until its timer expires. Only the bench scenarios can show the tick durations (press filter, hold delay, enable spacing, settle time, off time), the masking of a button held through the wait, and the two undervoltage recovery paths.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_UP   = 2'd1,
    ST_ON   = 2'd2,
    ST_WAIT = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pbs_tick_cnt.sv
module pbs_tick_cnt #(
  parameter int LIMIT = 1000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  // saturating counter never passes its limit
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LIM);
endmodule

// File: rtl/pbs_power_seq.sv
module pbs_power_seq #(
  parameter int N_BUCK      = 3,
  parameter int PRESS_MS    = 50,
  parameter int HOLD_MS     = 50,
  parameter int OFF_MS      = 1000,
  parameter int STEP_MS     = 10,
  parameter int SETTLE_MS   = 230,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              btn_n,
  input  logic              host_hold,
  input  logic              uv_flag,
  output logic              pb_stat,
  output logic              wake,
  output logic              pgood,
  output logic [N_BUCK-1:0] buck_en,
  output logic              ctl_clr
);
  import pbs_pkg::*;

  localparam int UP_MS  = (N_BUCK - 1) * STEP_MS + SETTLE_MS;
  localparam int MAX_A  = (OFF_MS > UP_MS) ? OFF_MS : UP_MS;
  localparam int MAX_MS = (MAX_A > HOLD_MS) ? MAX_A : HOLD_MS;
  localparam int TW     = $clog2(MAX_MS + 1);
  localparam int PW     = $clog2(PRESS_MS + 1);
  localparam logic [TW-1:0] T_UP   = TW'(UP_MS);
  localparam logic [TW-1:0] T_OFF  = TW'(OFF_MS);
  localparam logic [TW-1:0] T_HOLD = TW'(HOLD_MS);
  localparam logic [PW-1:0] T_PRESS = PW'(PRESS_MS);

  pwr_state_t state, nxt;
  logic btn_s;
  logic armed, auto_pend;
  logic tmr_clr, pcnt_clr, entering_wait;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pcnt;

  pbs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
    .clk(clk), .rst(rst), .d(btn_n), .q(btn_s)
  );

  // state timer, restarted on every transition and while the host holds power
  assign tmr_clr = (nxt != state) || (state == ST_ON && host_hold);

  pbs_tick_cnt #(.LIMIT(MAX_MS), .W(TW)) u_state_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(ms_tick), .cnt(tcnt)
  );

  // long-press filter, only runs while on and the button is down
  assign pcnt_clr = btn_s || (state != ST_ON);

  pbs_tick_cnt #(.LIMIT(PRESS_MS), .W(PW)) u_press_tmr (
    .clk(clk), .rst(rst), .clr(pcnt_clr), .tick(ms_tick), .cnt(pcnt)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:  if (!uv_flag && (auto_pend || (armed && !btn_s))) nxt = ST_UP;
      ST_UP:   if (uv_flag) nxt = ST_WAIT;
               else if (tcnt == T_UP) nxt = ST_ON;
      ST_ON:   if (uv_flag || (!host_hold && tcnt == T_HOLD)) nxt = ST_WAIT;
      ST_WAIT: if (tcnt == T_OFF) nxt = ST_OFF;
      default: nxt = ST_OFF;
    endcase
  end

  assign entering_wait = (state != ST_WAIT) && (nxt == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      armed     <= 1'b0;
      auto_pend <= 1'b0;
      ctl_clr   <= 1'b0;
    end else begin
      state   <= nxt;
      ctl_clr <= entering_wait;
      if (state == ST_WAIT || nxt == ST_UP) armed <= 1'b0;
      else if (state == ST_OFF && btn_s)    armed <= 1'b1;
      if (entering_wait)     auto_pend <= uv_flag;
      else if (nxt == ST_UP) auto_pend <= 1'b0;
    end
  end

  assign wake    = (state == ST_UP) || (state == ST_ON);
  assign pgood   = (state == ST_ON);
  assign pb_stat = (state == ST_ON) && (pcnt == T_PRESS);

  genvar gi;
  generate
    for (gi = 0; gi < N_BUCK; gi++) begin : g_buck
      localparam logic [TW-1:0] THR = TW'(gi * STEP_MS);
      assign buck_en[gi] = (state == ST_ON) || (state == ST_UP && tcnt >= THR);
      if (gi > 0) begin : g_order
        // R3
        buck_order_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(buck_en[gi]) |-> buck_en[gi-1]);
      end
    end
  endgenerate

  // R3
  pgood_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (buck_en == {N_BUCK{1'b1}}));

  // R4
  pb_stat_on_chk: assert property (@(posedge clk) disable iff (rst)
    pb_stat |-> (wake && pgood));

  // R6
  drop_together_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wake) |-> (buck_en == '0 && !pgood && ctl_clr));

  // R6
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |=> !ctl_clr);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && tcnt != T_OFF) |=> (state == ST_WAIT));

  // R9
  uv_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_flag && wake) |=> !wake);
endmodule

// File: tb/tb_pbs_power_seq.sv
module tb_pbs_power_seq;
  localparam int PRESS_MS  = 50;
  localparam int HOLD_MS   = 50;
  localparam int OFF_MS    = 1000;
  localparam int STEP_MS   = 10;
  localparam int SETTLE_MS = 230;
  localparam int TK        = 4;   // clock cycles per ms tick
  localparam int LIM       = 20000;

  logic clk = 0, rst = 1, ms_tick = 0, btn_n = 1, host_hold = 1, uv_flag = 0;
  logic pb_stat, wake, pgood, ctl_clr;
  logic [2:0] buck_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pbs_power_seq #(.N_BUCK(3), .PRESS_MS(PRESS_MS), .HOLD_MS(HOLD_MS), .OFF_MS(OFF_MS),
                  .STEP_MS(STEP_MS), .SETTLE_MS(SETTLE_MS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .btn_n(btn_n), .host_hold(host_hold),
    .uv_flag(uv_flag), .pb_stat(pb_stat), .wake(wake), .pgood(pgood),
    .buck_en(buck_en), .ctl_clr(ctl_clr)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (TK - 1) @(posedge clk);
      #1 ms_tick = 1;
      @(posedge clk);
      #1 ms_tick = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic logic sel(input int w);
    case (w)
      0, 1, 2: return buck_en[w];
      3:       return pgood;
      default: return !wake;
    endcase
  endfunction

  task automatic wait_sel(input int w, output int cyc);
    cyc = 0;
    while (!sel(w) && cyc < LIM) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic ms(input int n);
    repeat (n * TK) @(negedge clk);
  endtask

  task automatic bring_up();
    int c;
    @(negedge clk) btn_n = 0;
    wait_sel(0, c);
    btn_n = 1;
    wait_sel(3, c);
    ms(2);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (5) @(negedge clk);
    chk("R1", "outputs in reset", {wake, pgood, pb_stat, ctl_clr, buck_en}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "outputs after reset", {wake, pgood, pb_stat, ctl_clr, buck_en}, 0);
    ms(20);
    chk("R1", "stays off without press", {wake, buck_en}, 0);
  endtask

  task automatic t_powerup();
    int c;
    @(negedge clk) btn_n = 0;
    wait_sel(0, c);
    chk_rng("R2", "press to buck0 cycles", c, 1, 4);
    chk("R2", "wake with buck0", wake, 1);
    btn_n = 1;
    wait_sel(1, c);
    chk_rng("R3", "buck0 to buck1 cycles", c, STEP_MS * TK - TK, STEP_MS * TK + TK);
    chk("R3", "enables at buck1 rise", buck_en, 3'b011);
    wait_sel(2, c);
    chk_rng("R3", "buck1 to buck2 cycles", c, STEP_MS * TK - TK, STEP_MS * TK + TK);
    chk("R3", "enables at buck2 rise", buck_en, 3'b111);
    chk("R3", "pgood low before settle", pgood, 0);
    wait_sel(3, c);
    chk_rng("R3", "settle cycles", c, SETTLE_MS * TK - TK, SETTLE_MS * TK + TK);
  endtask

  task automatic t_press();
    @(negedge clk) btn_n = 0;
    ms(30);
    chk("R4", "short press pb_stat", pb_stat, 0);
    btn_n = 1;
    ms(3);
    btn_n = 0;
    ms(45);
    chk("R4", "pb_stat before limit", pb_stat, 0);
    ms(10);
    chk("R4", "pb_stat after limit", pb_stat, 1);
    btn_n = 1;
    ms(1);
    chk("R4", "pb_stat after release", pb_stat, 0);
    chk("R4", "still on after press", {wake, pgood}, 2'b11);
  endtask

  task automatic t_hold_down();
    int c;
    @(negedge clk) host_hold = 0;
    ms(30);
    host_hold = 1;
    ms(2);
    host_hold = 0;
    ms(40);
    chk("R5", "wake after restarted hold count", wake, 1);
    wait_sel(4, c);
    chk_rng("R5", "extra cycles to wake drop", c, 1, 12 * TK);
    chk("R6", "enables at wake drop", buck_en, 0);
    chk("R6", "pgood at wake drop", pgood, 0);
    chk("R6", "clear pulse at entry", ctl_clr, 1);
    @(negedge clk);
    chk("R6", "clear pulse one cycle", ctl_clr, 0);
    ms(100); btn_n = 0;
    ms(100); btn_n = 1; host_hold = 1;
    ms(100); btn_n = 0; uv_flag = 1;
    ms(100); btn_n = 1; uv_flag = 0;
    ms(500);
    chk("R7", "off during masked wait", {wake, pgood, buck_en, pb_stat}, 0);
    ms(200);
    chk("R7", "no power-up from masked inputs", {wake, buck_en}, 0);
  endtask

  task automatic t_held_through();
    int c;
    bring_up();
    @(negedge clk) host_hold = 0;
    wait_sel(4, c);
    host_hold = 1;
    btn_n = 0;
    ms(OFF_MS + 150);
    chk("R8", "held button after wait", {wake, buck_en}, 0);
    btn_n = 1;
    ms(5);
    chk("R8", "release alone stays off", wake, 0);
    btn_n = 0;
    ms(1);
    chk("R8", "fresh press powers up", wake, 1);
    btn_n = 1;
    wait_sel(3, c);
    ms(2);
  endtask

  task automatic t_uv_recover();
    int c;
    @(negedge clk) uv_flag = 1;
    @(negedge clk);
    chk("R9", "wake/pgood/enables after uv", {wake, pgood, buck_en}, 0);
    ms(100);
    uv_flag = 0;
    ms(OFF_MS - 150);
    chk("R10", "still off inside wait", {wake, buck_en}, 0);
    wait_sel(0, c);
    c = c + (OFF_MS - 50) * TK + 1;
    chk_rng("R10", "uv to auto re-up cycles", c, OFF_MS * TK - TK, OFF_MS * TK + 2 * TK);
    wait_sel(3, c);
    chk("R10", "auto re-up reaches on", pgood, 1);
    ms(2);
  endtask

  task automatic t_uv_persist();
    int c;
    @(negedge clk) uv_flag = 1;
    ms(OFF_MS + 200);
    chk("R10", "uv still high keeps off", {wake, buck_en}, 0);
    uv_flag = 0;
    @(negedge clk);
    wait_sel(0, c);
    chk_rng("R10", "re-up after uv clears", c, 0, 4);
    ms(3);
    uv_flag = 1;
    @(negedge clk);
    chk("R9", "uv during power-up drops wake", {wake, buck_en}, 0);
    uv_flag = 0;
    wait_sel(3, c);
    chk("R10", "recovers after uv in power-up", pgood, 1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_press();
    t_hold_down();
    t_held_through();
    t_uv_recover();
    t_uv_persist();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule